// File: doc/BRIEF.md
# Redundant dual-log adder/subtractor

This block adds or subtracts two numbers held in a redundant logarithmic form. Each number is a pair of base-2 logarithms, a positive part P and a negative part N, and its value is 2^P − 2^N. Each log field is a signed two's-complement fixed-point word with a zero flag beside it. A flagged field stands for a contribution of exactly zero. A positive input is therefore written as (log2 x, zero), and a negative input as (zero, log2 |x|).

Because the negative contributions stay in their own field, the block never needs the hard log-difference function. Addition combines the two positive parts in one lane and the two negative parts in a second, identical lane. Both lanes use only the easy correction sb(z) = log2(1 + 2^z). Subtraction exchanges the second operand's P and N fields before the lanes see them.

Each lane puts the larger of its inputs first, so it only needs sb of a non-positive argument. It reads that value from a direct table at the field's own fraction precision. Both lanes have the same two-register pipeline, so the result pair and its valid flag come out together. A new operation can start on every cycle. Turning the pair back into one signed number is left to the consumer.

Top module: `rdl_addsub`

The lane datapath has no state machine. It has two pipeline stages, and stage 1 picks one of four lane paths:
- ZERO: both inputs are flagged.
- PASS: exactly one input is flagged.
- FAR: the inputs differ by more than the limit.
- NEAR: otherwise.

Stage 2 forms the lane result from the path that stage 1 chose.

## Requirements
- R1: While reset is held and just after it, out_valid is 0 and both result fields have their zero flag at 1 and their log value at 0.
- R2: With in_sub at 0, the result's P field is the lane combination of a's P and b's P, and the result's N field is the lane combination of a's N and b's N. The two lanes are independent of each other.
- R3: In a lane where exactly one input has its zero flag set, the result is the other input with its log value unchanged and its zero flag at 0.
- R4: In a lane where both inputs have their zero flag set, the result has its zero flag at 1 and its log value at 0.
- R5: In a lane where both inputs are non-zero and their raw difference d is at most FRAC_W·2^FRAC_W, the result is the larger input plus round(2^FRAC_W · log2(1 + 2^(−d/2^FRAC_W))), rounded to nearest. Equal inputs therefore gain exactly 2^FRAC_W, which is +1.0.
- R6: In a lane where both inputs are non-zero and d is greater than FRAC_W·2^FRAC_W, the result is the larger input unchanged.
- R7: out_valid follows in_valid exactly two clock cycles later. Operations issued on consecutive cycles come out on consecutive cycles, each with its own result.
- R8: With in_sub at 1, b's P and N fields, flags included, are exchanged before the lanes combine them. The result is then a − b.
- R9: When the NEAR sum exceeds the largest positive log value (2^(LOG_W−1) − 1), that lane's result saturates to this maximum.
- R10: Log fields are signed two's complement with FRAC_W fraction bits. Negative logs, meaning magnitudes below one, are ordered and combined by their signed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the operand inputs |
| in_sub | input | 1 | 1 = subtract b from a, 0 = add |
| a_p_log | input | LOG_W | Operand a, positive-part log |
| a_p_zero | input | 1 | Operand a, positive part is zero |
| a_n_log | input | LOG_W | Operand a, negative-part log |
| a_n_zero | input | 1 | Operand a, negative part is zero |
| b_p_log | input | LOG_W | Operand b, positive-part log |
| b_p_zero | input | 1 | Operand b, positive part is zero |
| b_n_log | input | LOG_W | Operand b, negative-part log |
| b_n_zero | input | 1 | Operand b, negative part is zero |
| out_valid | output | 1 | Result pair valid |
| r_p_log | output | LOG_W | Result, positive-part log |
| r_p_zero | output | 1 | Result, positive part is zero |
| r_n_log | output | LOG_W | Result, negative-part log |
| r_n_zero | output | 1 | Result, negative part is zero |

## Verification
The hardest cases to reach from the ports sit at the edge between the NEAR and FAR paths. One test uses a difference of exactly the limit, which must still add a one-LSB correction. Another uses a difference one LSB above the limit, which must return the larger input untouched. The stimulus sets these raw differences directly, in both input orders. Saturation is reached by putting two operands close to the top of the signed log range so that the correction pushes the sum past the maximum. Back-to-back issue is driven on consecutive cycles to show that the results do not overlap.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    typedef enum logic [1:0] {
        PATH_ZERO = 2'd0,
        PATH_PASS = 2'd1,
        PATH_FAR  = 2'd2,
        PATH_NEAR = 2'd3
    } path_e;

    // Correction for a non-negative raw difference idx (frac fraction bits):
    // round(2^frac * log2(1 + 2^(-idx/2^frac))), elaboration-time only.
    function automatic int sb_code(int idx, int frac);
        real d;
        real v;
        d = real'(idx) / real'(1 << frac);
        v = $ln(1.0 + $exp(-d * $ln(2.0))) / $ln(2.0);
        return $rtoi(v * real'(1 << frac) + 0.5);
    endfunction

endpackage

// File: rtl/rdl_sb_rom.sv
module rdl_sb_rom #(
    parameter int FRAC_W = 4,
    parameter int DEPTH  = 65,
    parameter int IDX_W  = 7,
    parameter int CORR_W = 5
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CORR_W-1:0] corr
);
    localparam int SLOTS = 1 << IDX_W;

    logic [CORR_W-1:0] rom_w [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_entry
        if (i < DEPTH) begin : g_used
            localparam int CODE = rdl_pkg::sb_code(i, FRAC_W);
            assign rom_w[i] = CORR_W'(CODE);
        end else begin : g_spare
            assign rom_w[i] = '0;
        end
    end

    assign corr = rom_w[idx];

endmodule

// File: rtl/rdl_lane.sv
module rdl_lane
    import rdl_pkg::*;
#(
    parameter int LOG_W  = 10,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [LOG_W-1:0] x_log,
    input  logic                    x_zero,
    input  logic signed [LOG_W-1:0] y_log,
    input  logic                    y_zero,
    output logic signed [LOG_W-1:0] res_log,
    output logic                    res_zero
);
    localparam int LIMIT  = FRAC_W << FRAC_W;
    localparam int DEPTH  = LIMIT + 1;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CORR_W = FRAC_W + 1;
    localparam logic signed [LOG_W-1:0] MAX_LOG = {1'b0, {(LOG_W-1){1'b1}}};

    // Stage 1: order, difference, path choice
    logic signed [LOG_W-1:0] big_c;
    logic signed [LOG_W-1:0] small_c;
    logic        [LOG_W:0]   diff_c;
    path_e                   path_c;

    always_comb begin
        if (x_log >= y_log) begin
            big_c   = x_log;
            small_c = y_log;
        end else begin
            big_c   = y_log;
            small_c = x_log;
        end
        diff_c = {big_c[LOG_W-1], big_c} - {small_c[LOG_W-1], small_c};
        if (x_zero && y_zero)                  path_c = PATH_ZERO;
        else if (x_zero || y_zero)             path_c = PATH_PASS;
        else if (diff_c > (LOG_W+1)'(LIMIT))   path_c = PATH_FAR;
        else                                   path_c = PATH_NEAR;
        if (path_c == PATH_PASS) big_c = x_zero ? y_log : x_log;
    end

    path_e                   s1_path;
    logic signed [LOG_W-1:0] s1_big;
    logic        [IDX_W-1:0] s1_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_path <= PATH_ZERO;
            s1_big  <= '0;
            s1_idx  <= '0;
        end else begin
            s1_path <= path_c;
            s1_big  <= big_c;
            s1_idx  <= diff_c[IDX_W-1:0];
        end
    end

    // Stage 2: correction and saturation
    logic [CORR_W-1:0] corr;
    logic [LOG_W:0]    sum;
    logic signed [LOG_W-1:0] nxt_log;
    logic                    nxt_zero;

    rdl_sb_rom #(
        .FRAC_W (FRAC_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .CORR_W (CORR_W)
    ) i_rom (
        .idx  (s1_idx),
        .corr (corr)
    );

    always_comb begin
        sum      = {s1_big[LOG_W-1], s1_big} + {{(LOG_W+1-CORR_W){1'b0}}, corr};
        nxt_log  = s1_big;
        nxt_zero = 1'b0;
        unique case (s1_path)
            PATH_ZERO: begin
                nxt_log  = '0;
                nxt_zero = 1'b1;
            end
            PATH_PASS, PATH_FAR: nxt_log = s1_big;
            PATH_NEAR: nxt_log = (sum[LOG_W] != sum[LOG_W-1]) ? MAX_LOG : sum[LOG_W-1:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_log  <= '0;
            res_zero <= 1'b1;
        end else begin
            res_log  <= nxt_log;
            res_zero <= nxt_zero;
        end
    end

    // Lane properties
    p_both_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_zero && y_zero) |-> ##2 (res_zero && res_log == '0));

    p_pass_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_zero != y_zero) |-> ##2 (!res_zero && res_log == $past(x_zero ? y_log : x_log, 2)));

    p_never_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_zero && !y_zero) |-> ##2 (!res_zero && res_log >= $past(x_log, 2) && res_log >= $past(y_log, 2)));

    p_far_keeps_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_zero && !y_zero && diff_c > (LOG_W+1)'(LIMIT)) |-> ##2 (res_log == $past(big_c, 2)));

endmodule

// File: rtl/rdl_addsub.sv
module rdl_addsub #(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 4,
    parameter int LOG_W  = INT_W + FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sub,
    input  logic signed [LOG_W-1:0] a_p_log,
    input  logic                    a_p_zero,
    input  logic signed [LOG_W-1:0] a_n_log,
    input  logic                    a_n_zero,
    input  logic signed [LOG_W-1:0] b_p_log,
    input  logic                    b_p_zero,
    input  logic signed [LOG_W-1:0] b_n_log,
    input  logic                    b_n_zero,
    output logic                    out_valid,
    output logic signed [LOG_W-1:0] r_p_log,
    output logic                    r_p_zero,
    output logic signed [LOG_W-1:0] r_n_log,
    output logic                    r_n_zero
);
    localparam int STAGES = 2;

    // Subtraction: exchange b's parts
    logic signed [LOG_W-1:0] yp_log;
    logic signed [LOG_W-1:0] yn_log;
    logic                    yp_zero;
    logic                    yn_zero;

    always_comb begin
        yp_log  = in_sub ? b_n_log  : b_p_log;
        yp_zero = in_sub ? b_n_zero : b_p_zero;
        yn_log  = in_sub ? b_p_log  : b_n_log;
        yn_zero = in_sub ? b_p_zero : b_n_zero;
    end

    rdl_lane #(.LOG_W(LOG_W), .FRAC_W(FRAC_W)) i_lane_p (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_log    (a_p_log),
        .x_zero   (a_p_zero),
        .y_log    (yp_log),
        .y_zero   (yp_zero),
        .res_log  (r_p_log),
        .res_zero (r_p_zero)
    );

    rdl_lane #(.LOG_W(LOG_W), .FRAC_W(FRAC_W)) i_lane_n (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_log    (a_n_log),
        .x_zero   (a_n_zero),
        .y_log    (yn_log),
        .y_zero   (yn_zero),
        .res_log  (r_n_log),
        .res_zero (r_n_zero)
    );

    logic [STAGES-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[STAGES-2:0], in_valid};
    end

    assign out_valid = vld_q[STAGES-1];

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_idle_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    p_sub_swaps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sub && b_p_zero && !b_n_zero && a_p_zero) |-> ##2 (!r_p_zero && r_p_log == $past(b_n_log, 2)));

endmodule

// File: tb/test_rdl_addsub.sv
module test_rdl_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W  = 6;
    localparam int FRAC_W = 4;
    localparam int LOG_W  = INT_W + FRAC_W;
    localparam int LIMIT  = FRAC_W << FRAC_W;
    localparam int MAXL   = (1 << (LOG_W-1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sub = 1'b0;
    logic signed [LOG_W-1:0] a_p_log = '0, a_n_log = '0, b_p_log = '0, b_n_log = '0;
    logic a_p_zero = 1'b1, a_n_zero = 1'b1, b_p_zero = 1'b1, b_n_zero = 1'b1;
    logic out_valid;
    logic signed [LOG_W-1:0] r_p_log, r_n_log;
    logic r_p_zero, r_n_zero;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdl_addsub #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_rdl_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .a_p_log(a_p_log), .a_p_zero(a_p_zero), .a_n_log(a_n_log), .a_n_zero(a_n_zero),
        .b_p_log(b_p_log), .b_p_zero(b_p_zero), .b_n_log(b_n_log), .b_n_zero(b_n_zero),
        .out_valid(out_valid), .r_p_log(r_p_log), .r_p_zero(r_p_zero),
        .r_n_log(r_n_log), .r_n_zero(r_n_zero)
    );

    // Expected lane result from the requirements: returns {zero, log}
    function automatic logic [LOG_W:0] lane_model(int xl, bit xz, int yl, bit yz);
        int big, d, c, s;
        if (xz && yz) return {1'b1, {LOG_W{1'b0}}};
        if (xz) return {1'b0, LOG_W'(yl)};
        if (yz) return {1'b0, LOG_W'(xl)};
        big = (xl > yl) ? xl : yl;
        d = (xl > yl) ? xl - yl : yl - xl;
        if (d > LIMIT) return {1'b0, LOG_W'(big)};
        c = $rtoi(($ln(1.0 + 2.0 ** (-real'(d) / real'(1 << FRAC_W))) / $ln(2.0))
                  * real'(1 << FRAC_W) + 0.5);
        s = big + c;
        if (s > MAXL) s = MAXL;
        return {1'b0, LOG_W'(s)};
    endfunction

    task automatic drive(bit sub, int apl, bit apz, int anl, bit anz,
                         int bpl, bit bpz, int bnl, bit bnz);
        in_valid = 1'b1; in_sub = sub;
        a_p_log = LOG_W'(apl); a_p_zero = apz; a_n_log = LOG_W'(anl); a_n_zero = anz;
        b_p_log = LOG_W'(bpl); b_p_zero = bpz; b_n_log = LOG_W'(bnl); b_n_zero = bnz;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_sub = 1'b0;
    endtask

    task automatic check_out(string tag, bit ev, logic [LOG_W:0] ep, logic [LOG_W:0] en);
        n_run++;
        if (out_valid !== ev || {r_p_zero, r_p_log} !== ep || {r_n_zero, r_n_log} !== en) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b p=%0b/%0d n=%0b/%0d expected v=%0b p=%0b/%0d n=%0b/%0d",
                     tag, out_valid, r_p_zero, r_p_log, r_n_zero, r_n_log,
                     ev, ep[LOG_W], $signed(ep[LOG_W-1:0]), en[LOG_W], $signed(en[LOG_W-1:0]));
        end
    endtask

    // One operation, checked two cycles later
    task automatic one_op(string tag, bit sub, int apl, bit apz, int anl, bit anz,
                          int bpl, bit bpz, int bnl, bit bnz);
        logic [LOG_W:0] ep, en;
        if (sub) begin
            ep = lane_model(apl, apz, bnl, bnz);
            en = lane_model(anl, anz, bpl, bpz);
        end else begin
            ep = lane_model(apl, apz, bpl, bpz);
            en = lane_model(anl, anz, bnl, bnz);
        end
        @(negedge clk); drive(sub, apl, apz, anl, anz, bpl, bpz, bnl, bnz);
        @(negedge clk); idle();
        @(negedge clk); check_out(tag, 1'b1, ep, en);
    endtask

    task automatic t_reset();
        check_out("R1 reset state", 1'b0, {1'b1, {LOG_W{1'b0}}}, {1'b1, {LOG_W{1'b0}}});
    endtask

    task automatic t_add_lanes();
        one_op("R2 add both lanes", 0, 48, 0, 20, 0, 24, 0, 30, 0);
        one_op("R2 add positive only", 0, 48, 0, 0, 1, 24, 0, 0, 1);
    endtask

    task automatic t_near();
        one_op("R5 equal inputs add one", 0, 40, 0, 7, 0, 40, 0, 7, 0);
        one_op("R5 difference at limit", 0, 100, 0, 0, 1, 100 - LIMIT, 0, 0, 1);
        one_op("R5 limit other order", 0, 100 - LIMIT, 0, 0, 1, 100, 0, 0, 1);
    endtask

    task automatic t_far();
        one_op("R6 one past limit", 0, 100, 0, 0, 1, 100 - LIMIT - 1, 0, 0, 1);
        one_op("R6 far negative lane", 0, 0, 1, -200, 0, 0, 1, 150, 0);
    endtask

    task automatic t_zero();
        one_op("R3 one input zero", 0, 0, 1, 20, 0, 30, 0, 0, 1);
        one_op("R4 both zero", 0, 0, 1, 0, 1, 0, 1, 0, 1);
    endtask

    task automatic t_sub();
        one_op("R8 subtract swap", 1, 48, 0, 0, 1, 40, 0, 0, 1);
        one_op("R8 subtract four fields", 1, 10, 0, 33, 0, 50, 0, 12, 0);
    endtask

    task automatic t_neg_logs();
        one_op("R10 negative logs", 0, -100, 0, -300, 0, -90, 0, 5, 0);
    endtask

    task automatic t_sat();
        one_op("R9 saturate near top", 0, MAXL, 0, 505, 0, MAXL, 0, 500, 0);
    endtask

    task automatic t_stream();
        int pl[3] = '{16, -40, 200};
        int nl[3] = '{60, 61, -8};
        @(negedge clk); drive(0, pl[0], 0, nl[0], 0, pl[0] + 3, 0, nl[0], 1);
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 early valid: actual %0b expected 0", out_valid);
        end
        drive(0, pl[1], 0, nl[1], 0, pl[1] + 3, 0, nl[1], 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_out($sformatf("R7 stream result %0d", k), 1'b1,
                      lane_model(pl[k], 0, pl[k] + 3, 0), lane_model(nl[k], 0, nl[k], 1));
            if (k == 0) drive(0, pl[2], 0, nl[2], 0, pl[2] + 3, 0, nl[2], 1);
            else idle();
        end
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 valid after stream: actual %0b expected 0", out_valid);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_lanes();
        t_near();
        t_far();
        t_zero();
        t_sub();
        t_neg_logs();
        t_sat();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule